// File: doc/BRIEF.md
# Dual-Address DMA Channel Sequencer

This block is a single DMA channel that moves a block of operands from a source address to a destination address on a simple master bus. Software programs the source address, the destination address, a byte count and a control word through a small register port, then sets the start bit. Before each operand the channel wins the bus through a request / grant / grant-acknowledge handshake. It runs a read cycle at the source and then a write cycle at the destination, and gives the bus back after the write.

A transfer can be requested in two ways. In internal mode the channel requests as soon as the start bit is set. In external mode it also waits for a peripheral request input. Each address can advance by the operand size or stay fixed, which suits a peripheral data register. In single-address mode the destination device supplies the data, so the channel drives only the destination write and leaves the source register alone. A DMA qualifier line stays high from the start of the read until the end of the write. A status word reports busy, normal completion or a bus error.

Top module: `dma_chan_seq`

## Requirements
- R1: The bus is requested with `br` only from a request state. `bgack` rises only after `bg` has been seen, and `br` is low while `bgack` is high. `m_strb` is driven only while `bgack` is high.
- R2: In internal mode (control bit 1 = 0), when a control write sets start (bit 0) and the count is nonzero, `br` is high in the cycle after the write's clock edge, and `bgack` is still low.
- R3: In external mode (control bit 1 = 1), `br` stays low while `dreq` is low, even though start is set.
- R4: `m_fc3` is high during every acknowledged bus cycle of an operand. After a successful read it stays high into the write, with no gap.
- R5: Each recognised request moves exactly one operand: a read at the source address (`m_rw`=1), then a write of that read data at the destination address (`m_rw`=0). After that the bus is released.
- R6: The operand size is control bits [6:5] (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes). The source address advances by that size after each read when bit 3 is set. The destination advances after each write when bit 4 is set. A clear bit keeps the address fixed.
- R7: After each write the count drops by the operand size, saturating at zero. When it reaches zero, the start bit clears and the status reads done. Status register (index 4): bit 0 busy, bit 1 done, bit 2 bus error. Done and bus error never hold together.
- R8: An `m_berr` on a read or a write has several effects. It sets the bus-error flag and clears start. It drops `bgack` and `m_strb` in the next cycle. The register that did not complete its cycle keeps its value, and the count is left unchanged.
- R9: In single-address mode (control bit 2 = 1), the channel issues only write cycles to the destination, and the source register keeps its value.
- R10: If software clears start while the channel is idle between operands, a later `dreq` does not cause a bus request and the count is not changed.
- R11: After reset, `br`, `bgack`, `m_strb` and `m_fc3` are low, and every register reads zero. The register indices are 0 source, 1 destination, 2 count, 3 control and 4 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register index |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data (combinational on cfg_addr) |
| dreq | input | 1 | External transfer request |
| br | output | 1 | Bus request |
| bg | input | 1 | Bus grant |
| bgack | output | 1 | Grant acknowledge, high while the channel owns the bus |
| m_addr | output | AW | Bus address |
| m_strb | output | 1 | Cycle strobe |
| m_rw | output | 1 | 1 = read, 0 = write |
| m_fc3 | output | 1 | DMA qualifier line |
| m_size | output | 2 | Operand size code |
| m_wdata | output | DW | Write data |
| m_rdata | input | DW | Read data |
| m_ack | input | 1 | Cycle acknowledge |
| m_berr | input | 1 | Cycle bus error |

## Verification
A word block with both addresses advancing shows the read-then-write pairing and the data forwarding across several operands. A byte block with a fixed destination shows that the increment bits and the size code act on each register separately. In external mode a single `dreq` pulse followed by cleared start separates one-operand-per-request from free running and from a stop that is ignored. A single-address block shows that no reads occur and the source is untouched. An error injected on a write shows the abort path leaving the destination and the count frozen.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } dma_state_t;

    // control word, packed from bit 6 down to bit 0
    typedef struct packed {
        logic [1:0] size;     // [6:5]
        logic       dst_inc;  // [4]
        logic       src_inc;  // [3]
        logic       single;   // [2]
        logic       ext;      // [1]
        logic       start;    // [0]
    } dma_ctrl_t;

    localparam int CTRL_W = $bits(dma_ctrl_t);

    localparam logic [2:0] RA_SRC  = 3'd0;
    localparam logic [2:0] RA_DST  = 3'd1;
    localparam logic [2:0] RA_CNT  = 3'd2;
    localparam logic [2:0] RA_CTRL = 3'd3;
    localparam logic [2:0] RA_STAT = 3'd4;

    function automatic logic [2:0] op_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    op_bytes = 3'd1;
            2'd1:    op_bytes = 3'd2;
            default: op_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          adv,
    input  logic          inc_en,
    input  logic [2:0]    step,
    output logic [AW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= ld_val;
        else if (adv && inc_en)
            q <= q + AW'(step);
    end
endmodule

// File: rtl/dma_req_qual.sv
module dma_req_qual #(
    parameter int SYNC = 0
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic ext_mode,
    input  logic dreq,
    input  logic cnt_nz,
    output logic go
);
    logic dreq_s;

    generate
        if (SYNC == 0) begin : g_direct
            assign dreq_s = dreq;
        end else begin : g_sync
            logic [SYNC-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= (sh << 1) | SYNC'(dreq);
            end
            assign dreq_s = sh[SYNC-1];
        end
    endgenerate

    assign go = start && cnt_nz && (!ext_mode || dreq_s);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int AW        = 32,
    parameter int DW        = 32,
    parameter int CW        = 16,
    parameter int DREQ_SYNC = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [DW-1:0] cfg_wdata,
    output logic [DW-1:0] cfg_rdata,
    input  logic          dreq,
    output logic          br,
    input  logic          bg,
    output logic          bgack,
    output logic [AW-1:0] m_addr,
    output logic          m_strb,
    output logic          m_rw,
    output logic          m_fc3,
    output logic [1:0]    m_size,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ack,
    input  logic          m_berr
);
    dma_state_t      state_q, state_d;
    dma_ctrl_t       ctrl_q;
    logic [CW-1:0]   cnt_q;
    logic [DW-1:0]   hold_q;
    logic            done_q, err_q;
    logic [AW-1:0]   src_q, dst_q;
    logic [2:0]      step;
    logic            go, rd_ok, wr_ok, fault, last;
    logic            wr_ctrl, arm;
    logic            ctl_single;

    assign step       = op_bytes(ctrl_q.size);
    assign ctl_single = ctrl_q.single;
    assign wr_ctrl    = cfg_we && (cfg_addr == RA_CTRL);
    assign arm        = wr_ctrl && cfg_wdata[0];
    assign rd_ok      = (state_q == ST_RD) && m_ack && !m_berr;
    assign wr_ok      = (state_q == ST_WR) && m_ack && !m_berr;
    assign fault      = ((state_q == ST_RD) || (state_q == ST_WR)) && m_berr;
    assign last       = cnt_q <= CW'(step);

    dma_req_qual #(.SYNC(DREQ_SYNC)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .start    (ctrl_q.start),
        .ext_mode (ctrl_q.ext),
        .dreq     (dreq),
        .cnt_nz   (cnt_q != '0),
        .go       (go)
    );

    dma_addr_reg #(.AW(AW)) u_src (
        .clk    (clk),
        .rst    (rst),
        .ld     (cfg_we && (cfg_addr == RA_SRC)),
        .ld_val (cfg_wdata[AW-1:0]),
        .adv    (rd_ok),
        .inc_en (ctrl_q.src_inc),
        .step   (step),
        .q      (src_q)
    );

    dma_addr_reg #(.AW(AW)) u_dst (
        .clk    (clk),
        .rst    (rst),
        .ld     (cfg_we && (cfg_addr == RA_DST)),
        .ld_val (cfg_wdata[AW-1:0]),
        .adv    (wr_ok),
        .inc_en (ctrl_q.dst_inc),
        .step   (step),
        .q      (dst_q)
    );

    // operand sequencer
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (go) state_d = ST_REQ;
            ST_REQ:  if (bg) state_d = ctrl_q.single ? ST_WR : ST_RD;
            ST_RD: begin
                if (fault)      state_d = ST_IDLE;
                else if (rd_ok) state_d = ST_WR;
            end
            ST_WR:   if (fault || wr_ok) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctrl_q  <= '0;
            cnt_q   <= '0;
            hold_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (rd_ok)
                hold_q <= m_rdata;
            if (cfg_we && (cfg_addr == RA_CNT))
                cnt_q <= cfg_wdata[CW-1:0];
            else if (wr_ok)
                cnt_q <= last ? '0 : cnt_q - CW'(step);
            if (wr_ctrl)
                ctrl_q <= dma_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            else if (fault || (wr_ok && last))
                ctrl_q.start <= 1'b0;
            if (arm) begin
                done_q <= 1'b0;
                err_q  <= 1'b0;
            end else if (fault) begin
                err_q  <= 1'b1;
            end else if (wr_ok && last) begin
                done_q <= 1'b1;
            end
        end
    end

    assign br      = (state_q == ST_REQ);
    assign bgack   = (state_q == ST_RD) || (state_q == ST_WR);
    assign m_strb  = bgack;
    assign m_fc3   = bgack;
    assign m_rw    = (state_q == ST_RD);
    assign m_addr  = (state_q == ST_RD) ? src_q : dst_q;
    assign m_size  = ctrl_q.size;
    assign m_wdata = hold_q;

    always_comb begin
        case (cfg_addr)
            RA_SRC:  cfg_rdata = DW'(src_q);
            RA_DST:  cfg_rdata = DW'(dst_q);
            RA_CNT:  cfg_rdata = DW'(cnt_q);
            RA_CTRL: cfg_rdata = DW'(ctrl_q);
            RA_STAT: cfg_rdata = DW'({err_q, done_q, state_q != ST_IDLE});
            default: cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk (
    input logic clk,
    input logic rst,
    input logic br,
    input logic bgack,
    input logic m_strb,
    input logic m_rw,
    input logic m_fc3,
    input logic m_ack,
    input logic m_berr,
    input logic done_q,
    input logic err_q,
    input logic single_mode
);
    assert_no_req_while_owner_R1: assert property (@(posedge clk) disable iff (rst)
        bgack |-> !br);

    assert_strobe_needs_owner_R1: assert property (@(posedge clk) disable iff (rst)
        m_strb |-> bgack);

    assert_fc3_spans_operand_R4: assert property (@(posedge clk) disable iff (rst)
        (m_strb && m_rw && m_ack && !m_berr) |=> (m_fc3 && m_strb && !m_rw));

    assert_fc3_on_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (m_strb && m_ack) |-> m_fc3);

    assert_done_err_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(done_q && err_q));

    assert_berr_releases_R8: assert property (@(posedge clk) disable iff (rst)
        (m_strb && m_berr) |=> (!bgack && !m_strb));

    assert_single_no_read_R9: assert property (@(posedge clk) disable iff (rst)
        (m_strb && single_mode) |-> !m_rw);
endmodule

bind dma_chan_seq dma_chan_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .br          (br),
    .bgack       (bgack),
    .m_strb      (m_strb),
    .m_rw        (m_rw),
    .m_fc3       (m_fc3),
    .m_ack       (m_ack),
    .m_berr      (m_berr),
    .done_q      (done_q),
    .err_q       (err_q),
    .single_mode (ctl_single)
);

// File: tb/dma_chan_seq_test.sv
`timescale 1ns/1ps
module dma_chan_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dreq = 1'b0;
    logic        br, bgack, bg = 1'b0;
    logic [31:0] m_addr, m_wdata, m_rdata;
    logic        m_strb, m_rw, m_fc3;
    logic [1:0]  m_size;
    logic        m_ack = 1'b0, m_berr = 1'b0;

    always #2 clk = ~clk;

    function automatic logic [31:0] memfn(input logic [31:0] a);
        return (a * 32'h01010101) ^ 32'h5A5A0000;
    endfunction
    assign m_rdata = memfn(m_addr);

    dma_chan_seq uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dreq(dreq),
        .br(br), .bg(bg), .bgack(bgack), .m_addr(m_addr), .m_strb(m_strb),
        .m_rw(m_rw), .m_fc3(m_fc3), .m_size(m_size), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ack(m_ack), .m_berr(m_berr)
    );

    typedef struct {
        logic        rw;
        logic [31:0] addr;
        logic [31:0] data;
        logic        chk_data;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int n_chk = 0, n_err = 0;
    int n_acks = 0, wr_seen = 0, berr_at = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: expected bus cycles of a block
    task automatic push_block(input logic [31:0] src, input logic [31:0] dst,
                              input int cnt, input int sz, input bit si,
                              input bit di, input bit single, input int max_ops);
        int ops = (cnt + sz - 1) / sz;
        if (max_ops < ops) ops = max_ops;
        for (int k = 0; k < ops; k++) begin
            logic [31:0] s = si ? src + k * sz : src;
            logic [31:0] d = di ? dst + k * sz : dst;
            if (!single)
                exp_q.push_back('{1'b1, s, 32'h0, 1'b0, "R5 read"});
            exp_q.push_back('{1'b0, d, memfn(s), !single, "R5 write"});
        end
    endtask

    // responder and monitor
    initial begin
        forever begin
            @(negedge clk);
            bg = br;
            if (m_ack || m_berr) begin
                m_ack = 1'b0;
                m_berr = 1'b0;
            end else if (m_strb) begin
                item_t it;
                n_acks++;
                if (n_acks == berr_at) m_berr = 1'b1;
                else                   m_ack = 1'b1;
                chk("R4 qualifier during cycle", m_fc3, 1'b1);
                chk("R1 strobe with ownership", bgack, 1'b1);
                if (exp_q.size() == 0) begin
                    chk("R5 unexpected bus cycle", 32'h1, 32'h0);
                end else begin
                    it = exp_q.pop_front();
                    chk({it.tag, " direction"}, m_rw, it.rw);
                    chk({it.tag, " address"}, m_addr, it.addr);
                    if (it.chk_data && !m_rw)
                        chk({it.tag, " data"}, m_wdata, it.data);
                end
                if (!m_rw && m_ack) wr_seen++;
            end
        end
    end

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #0.5;
        d = cfg_rdata;
    endtask

    task automatic wait_end();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            cfg_rd(3'd4, s);
            if (s[1] || s[2]) break;
        end
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 3000 && wr_seen < n; i++) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int base, brs;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 br", br, 1'b0);
        chk("R11 bgack", bgack, 1'b0);
        chk("R11 strobe", m_strb, 1'b0);
        chk("R11 fc3", m_fc3, 1'b0);
        cfg_rd(3'd4, v); chk("R11 status", v, 0);
        cfg_rd(3'd2, v); chk("R11 count", v, 0);

        // internal word block, both increment
        cfg_wr(3'd0, 32'h100);
        cfg_wr(3'd1, 32'h200);
        cfg_wr(3'd2, 8);
        push_block(32'h100, 32'h200, 8, 4, 1, 1, 0, 99);
        cfg_wr(3'd3, 32'h59);
        @(negedge clk);
        chk("R2 request after start", br, 1'b1);
        chk("R1 no ack before grant", bgack, 1'b0);
        wait_end();
        chk("R5 all cycles seen", exp_q.size(), 0);
        cfg_rd(3'd4, v); chk("R7 done status", v, 2);
        cfg_rd(3'd2, v); chk("R7 count zero", v, 0);
        cfg_rd(3'd3, v); chk("R7 start cleared", v[0], 1'b0);
        cfg_rd(3'd0, v); chk("R6 src advanced", v, 32'h108);
        cfg_rd(3'd1, v); chk("R6 dst advanced", v, 32'h208);
        chk("R8 bus released", bgack, 1'b0);

        // byte block, destination fixed
        cfg_wr(3'd0, 32'h40);
        cfg_wr(3'd1, 32'h80);
        cfg_wr(3'd2, 3);
        push_block(32'h40, 32'h80, 3, 1, 1, 0, 0, 99);
        cfg_wr(3'd3, 32'h09);
        wait_end();
        chk("R5 byte cycles seen", exp_q.size(), 0);
        cfg_rd(3'd0, v); chk("R6 src byte steps", v, 32'h43);
        cfg_rd(3'd1, v); chk("R6 dst fixed", v, 32'h80);

        // external request mode
        cfg_wr(3'd0, 32'h500);
        cfg_wr(3'd1, 32'h600);
        cfg_wr(3'd2, 8);
        cfg_wr(3'd3, 32'h5B);
        brs = 0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (br) brs++; end
        chk("R3 no request without dreq", brs, 0);
        push_block(32'h500, 32'h600, 8, 4, 1, 1, 0, 1);
        base = wr_seen;
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
        wait_writes(base + 1);
        repeat (8) @(negedge clk);
        chk("R5 one operand per request", exp_q.size(), 0);
        cfg_rd(3'd2, v); chk("R5 count after one request", v, 4);
        cfg_rd(3'd4, v); chk("R5 idle after operand", v, 0);
        // R10: stop between operands
        cfg_wr(3'd3, 32'h5A);
        brs = 0;
        dreq = 1'b1;
        for (int i = 0; i < 10; i++) begin @(negedge clk); if (br) brs++; end
        dreq = 1'b0;
        chk("R10 no request after stop", brs, 0);
        cfg_rd(3'd2, v); chk("R10 count unchanged", v, 4);

        // single-address, halfword, destination increments
        cfg_wr(3'd0, 32'h300);
        cfg_wr(3'd1, 32'h400);
        cfg_wr(3'd2, 4);
        push_block(32'h300, 32'h400, 4, 2, 1, 1, 1, 99);
        cfg_wr(3'd3, 32'h35);
        wait_end();
        chk("R9 writes only", exp_q.size(), 0);
        cfg_rd(3'd0, v); chk("R9 src untouched", v, 32'h300);
        cfg_rd(3'd1, v); chk("R9 dst advanced", v, 32'h404);
        cfg_rd(3'd4, v); chk("R7 single done", v, 2);

        // bus error on the first write
        cfg_wr(3'd0, 32'h700);
        cfg_wr(3'd1, 32'h780);
        cfg_wr(3'd2, 8);
        push_block(32'h700, 32'h780, 8, 4, 1, 1, 0, 1);
        berr_at = n_acks + 2;
        cfg_wr(3'd3, 32'h59);
        wait_end();
        repeat (4) @(negedge clk);
        chk("R8 no cycles after error", exp_q.size(), 0);
        cfg_rd(3'd4, v); chk("R8 error status", v, 4);
        cfg_rd(3'd0, v); chk("R8 src after read", v, 32'h704);
        cfg_rd(3'd1, v); chk("R8 dst frozen", v, 32'h780);
        cfg_rd(3'd2, v); chk("R8 count frozen", v, 8);
        cfg_rd(3'd3, v); chk("R8 start cleared", v[0], 1'b0);
        chk("R8 bus released", bgack, 1'b0);
        berr_at = 0;

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule